// File: doc/BRIEF.md
# Section Overhead Byte Inserter

This block sits in a byte-serial transmit path ahead of the scrambler and overwrites selected section overhead bytes with programmed values. Upstream logic presents one byte per valid cycle, flags the first byte of each frame, and raises one marker per byte that occupies an overhead slot: the two single-byte slots carried from software registers (here called the orderwire byte and the user-channel byte), the section trace slot, and the growth (Z0) slots.

Software loads a shadow copy of every stored value through one write port. At each start-of-frame byte the shadow copies move into the active copies used for insertion, so a frame never mixes old and new contents. The trace slot steps through a stored message one byte per trace slot, repeating every 64 or every 16 bytes as selected at run time. Each group can be switched to pass-through on its own. Overhead markers are never placed on the start-of-frame byte.

Top module: `soh_inserter`

## Requirements
- R1: Every byte appears on the output one cycle after it is taken, with `out_valid` and `out_sof` copied from `in_valid` and `in_sof`. A byte that carries no overhead marker leaves unchanged.
- R2: A valid byte with `at_e1` set and `cfg_e1_off` clear is replaced by the active orderwire register (write select 0).
- R3: A valid byte with `at_f1` set and `cfg_f1_off` clear is replaced by the active user-channel register (write select 1). `at_e1` takes priority over `at_f1`, `at_j0` and `at_z0`.
- R4: With `cfg_trace_short` at 0, successive trace slots carry trace entries 0,1,…,63 and then wrap to 0. Trace entries are written with write select 2, and `wr_addr` is the entry number.
- R5: With `cfg_trace_short` at 1, successive trace slots carry entries 0 to 15 and then wrap to 0.
- R6: When `cfg_trace_short` differs at a start-of-frame byte from the value in use, the first trace slot after that start of frame carries entry 0.
- R7: The growth slots of a frame carry Z0 entries 0,1,…,Z0_COUNT-1, counted in the order they occur after the start of frame. Further growth slots in that frame pass through. Entries are written with write select 3, and `wr_addr` is the entry number. Addresses at Z0_COUNT or above are ignored.
- R8: When a group's disable bit is set (`cfg_e1_off`, `cfg_f1_off`, `cfg_j0_off`, `cfg_z0_off`), bytes at that group's slots pass through unchanged. The trace index still advances on each trace slot.
- R9: A write takes effect at the first start-of-frame byte after the write cycle. A write in the same cycle as a start-of-frame byte reaches the frame after that one.
- R10: After reset, `out_valid`, `out_sof` and `out_data` are 0, and all stored values and the trace index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Upstream byte |
| in_valid | input | 1 | Byte valid |
| in_sof | input | 1 | First byte of a frame |
| at_e1 | input | 1 | Orderwire slot marker |
| at_f1 | input | 1 | User-channel slot marker |
| at_j0 | input | 1 | Trace slot marker |
| at_z0 | input | 1 | Growth slot marker |
| cfg_e1_off | input | 1 | Orderwire pass-through |
| cfg_f1_off | input | 1 | User-channel pass-through |
| cfg_j0_off | input | 1 | Trace pass-through |
| cfg_z0_off | input | 1 | Growth pass-through |
| cfg_trace_short | input | 1 | 0: 64-byte trace, 1: 16-byte trace |
| wr_en | input | 1 | Storage write strobe |
| wr_sel | input | 2 | Write target: 0 orderwire, 1 user channel, 2 trace, 3 Z0 |
| wr_addr | input | 6 | Entry number for trace or Z0 writes |
| wr_data | input | 8 | Write value |
| out_data | output | 8 | Outgoing byte |
| out_valid | output | 1 | Outgoing byte valid |
| out_sof | output | 1 | Outgoing first byte of frame |

## Verification
Each result is due exactly one clock after the byte that causes it. The output register is the only stage between the inputs and the outputs. The bench drives each byte on a falling edge, advances its reference model at the following rising edge, and compares at the next falling edge, so every comparison falls one register later than its stimulus. Writes and length changes are tracked by the model relative to the start-of-frame edge at which they commit. Frames are arranged so that bytes just before and just after that edge test R9 and R6.

// File: rtl/soh_inserter.sv
module soh_inserter #(
  parameter int TRACE_LEN = 64,
  parameter int SHORT_LEN = 16,
  parameter int Z0_COUNT  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       at_e1,
  input  logic       at_f1,
  input  logic       at_j0,
  input  logic       at_z0,
  input  logic       cfg_e1_off,
  input  logic       cfg_f1_off,
  input  logic       cfg_j0_off,
  input  logic       cfg_z0_off,
  input  logic       cfg_trace_short,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [5:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof
);
  localparam int TAW = $clog2(TRACE_LEN);
  localparam int ZAW = (Z0_COUNT > 1) ? $clog2(Z0_COUNT) : 1;
  localparam int ZCW = $clog2(Z0_COUNT + 1);

  logic [7:0] e1_sh, e1_act, f1_sh, f1_act;
  logic [7:0] tr_sh [TRACE_LEN];
  logic [7:0] tr_act[TRACE_LEN];
  logic [7:0] z0_sh [Z0_COUNT];
  logic [7:0] z0_act[Z0_COUNT];
  logic [TAW-1:0] j0_idx, j0_last;
  logic [ZCW-1:0] z0_cnt;
  logic short_q;
  logic [7:0] nxt;

  wire frame_start = in_valid & in_sof;
  wire z0_room     = z0_cnt < ZCW'(Z0_COUNT);
  assign j0_last   = short_q ? TAW'(SHORT_LEN - 1) : TAW'(TRACE_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_sh <= '0; e1_act <= '0; f1_sh <= '0; f1_act <= '0;
      for (int i = 0; i < TRACE_LEN; i++) begin tr_sh[i] <= '0; tr_act[i] <= '0; end
      for (int i = 0; i < Z0_COUNT; i++) begin z0_sh[i] <= '0; z0_act[i] <= '0; end
    end else begin
      if (frame_start) begin
        e1_act <= e1_sh;
        f1_act <= f1_sh;
        tr_act <= tr_sh;
        z0_act <= z0_sh;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: e1_sh <= wr_data;
          2'd1: f1_sh <= wr_data;
          2'd2: if (int'(wr_addr) < TRACE_LEN) tr_sh[wr_addr[TAW-1:0]] <= wr_data;
          default: if (int'(wr_addr) < Z0_COUNT) z0_sh[wr_addr[ZAW-1:0]] <= wr_data;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      j0_idx  <= '0;
      short_q <= 1'b0;
      z0_cnt  <= '0;
    end else begin
      if (frame_start && cfg_trace_short != short_q) begin
        j0_idx  <= '0;
        short_q <= cfg_trace_short;
      end else if (in_valid && at_j0) begin
        j0_idx <= (j0_idx == j0_last) ? '0 : j0_idx + 1'b1;
      end
      if (frame_start) z0_cnt <= '0;
      else if (in_valid && at_z0 && z0_room) z0_cnt <= z0_cnt + 1'b1;
    end
  end

  always_comb begin
    nxt = in_data;
    if (in_valid) begin
      if (at_e1) begin
        if (!cfg_e1_off) nxt = e1_act;
      end else if (at_f1) begin
        if (!cfg_f1_off) nxt = f1_act;
      end else if (at_j0) begin
        if (!cfg_j0_off) nxt = tr_act[j0_idx];
      end else if (at_z0 && !cfg_z0_off && z0_room) begin
        nxt = z0_act[z0_cnt[ZAW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      out_data  <= nxt;
      out_valid <= in_valid;
      out_sof   <= in_sof;
    end
  end
endmodule

// File: rtl/soh_inserter_chk.sv
module soh_inserter_chk #(
  parameter int TRACE_LEN = 64,
  parameter int SHORT_LEN = 16,
  parameter int TAW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     in_data,
  input logic           in_valid,
  input logic           in_sof,
  input logic           at_e1,
  input logic           at_f1,
  input logic           at_j0,
  input logic           at_z0,
  input logic           cfg_e1_off,
  input logic           cfg_f1_off,
  input logic           cfg_j0_off,
  input logic           cfg_z0_off,
  input logic           cfg_trace_short,
  input logic [7:0]     e1_act,
  input logic [7:0]     f1_act,
  input logic [TAW-1:0] j0_idx,
  input logic           short_q,
  input logic [7:0]     out_data,
  input logic           out_valid,
  input logic           out_sof
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)) && (out_sof == $past(in_sof)));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !(at_e1 || at_f1 || at_j0 || at_z0) |=> out_data == $past(in_data));

  p_e1_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && at_e1 && !cfg_e1_off |=> out_data == $past(e1_act));

  p_f1_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !at_e1 && at_f1 && !cfg_f1_off |=> out_data == $past(f1_act));

  p_trace_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(j0_idx) < (short_q ? SHORT_LEN : TRACE_LEN));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && (cfg_trace_short != short_q) |=> j0_idx == '0);

  p_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cfg_e1_off && cfg_f1_off && cfg_j0_off && cfg_z0_off
      |=> out_data == $past(in_data));
endmodule

bind soh_inserter soh_inserter_chk #(.TRACE_LEN(TRACE_LEN), .SHORT_LEN(SHORT_LEN), .TAW(TAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof),
  .at_e1(at_e1), .at_f1(at_f1), .at_j0(at_j0), .at_z0(at_z0),
  .cfg_e1_off(cfg_e1_off), .cfg_f1_off(cfg_f1_off), .cfg_j0_off(cfg_j0_off),
  .cfg_z0_off(cfg_z0_off), .cfg_trace_short(cfg_trace_short),
  .e1_act(e1_act), .f1_act(f1_act), .j0_idx(j0_idx), .short_q(short_q),
  .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof));

// File: tb/soh_inserter_tb_top.sv
module soh_inserter_tb_top;
  localparam int TL = 64, SL = 16, ZC = 3;

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = 0, wr_data = 0;
  logic in_valid = 0, in_sof = 0, at_e1 = 0, at_f1 = 0, at_j0 = 0, at_z0 = 0;
  logic cfg_e1_off = 0, cfg_f1_off = 0, cfg_j0_off = 0, cfg_z0_off = 0, cfg_trace_short = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [5:0] wr_addr = 0;
  logic [7:0] out_data;
  logic out_valid, out_sof;

  always #10 clk = ~clk;

  soh_inserter #(.TRACE_LEN(TL), .SHORT_LEN(SL), .Z0_COUNT(ZC)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_e1_sh = 0, m_e1 = 0, m_f1_sh = 0, m_f1 = 0;
  logic [7:0] m_tr_sh[TL], m_tr[TL], m_z_sh[ZC], m_z[ZC];
  int m_idx = 0, m_zc = 0;
  bit m_short = 0, m_restarted = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(logic [7:0] d, output string tag);
    tag = "R1";
    if (!in_valid) return d;
    if (at_e1) begin
      if (cfg_e1_off) begin tag = "R8"; return d; end
      tag = (m_e1 != m_e1_sh) ? "R9" : "R2"; return m_e1;
    end
    if (at_f1) begin
      if (cfg_f1_off) begin tag = "R8"; return d; end
      tag = (m_f1 != m_f1_sh) ? "R9" : "R3"; return m_f1;
    end
    if (at_j0) begin
      if (cfg_j0_off) begin tag = "R8"; return d; end
      tag = m_restarted ? "R6" : (m_short ? "R5" : "R4"); return m_tr[m_idx];
    end
    if (at_z0 && m_zc < ZC) begin
      if (cfg_z0_off) begin tag = "R8"; return d; end
      tag = "R7"; return m_z[m_zc];
    end
    if (at_z0) tag = "R7";
    return d;
  endfunction

  task automatic cyc(bit v, bit s, bit e1, bit f1, bit j0, bit z0, logic [7:0] d);
    logic [7:0] exp;
    string tag;
    bit fs;
    in_valid = v; in_sof = s; at_e1 = e1; at_f1 = f1; at_j0 = j0; at_z0 = z0; in_data = d;
    wr_en = ($urandom_range(0, 5) == 0);
    wr_sel = 2'($urandom_range(0, 3));
    wr_addr = (wr_sel == 2) ? 6'($urandom_range(0, TL - 1)) : 6'($urandom_range(0, ZC));
    wr_data = 8'($urandom);
    exp = expect_byte(d, tag);
    fs = v && s;
    if (fs) begin
      m_e1 = m_e1_sh; m_f1 = m_f1_sh;
      for (int i = 0; i < TL; i++) m_tr[i] = m_tr_sh[i];
      for (int i = 0; i < ZC; i++) m_z[i] = m_z_sh[i];
      m_zc = 0;
    end
    if (fs && cfg_trace_short != m_short) begin
      m_idx = 0; m_short = cfg_trace_short; m_restarted = 1;
    end else if (v && j0) begin
      m_idx = (m_idx == (m_short ? SL : TL) - 1) ? 0 : m_idx + 1;
      m_restarted = 0;
    end
    if (v && z0 && !fs && m_zc < ZC) m_zc++;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_e1_sh = wr_data;
        2'd1: m_f1_sh = wr_data;
        2'd2: m_tr_sh[wr_addr] = wr_data;
        default: if (wr_addr < ZC) m_z_sh[wr_addr] = wr_data;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(out_valid == v && out_sof == s, "R1", {out_valid, out_sof}, {v, s});
    if (v) check(out_data == exp, tag, out_data, exp);
  endtask

  task automatic frame(bit gaps);
    for (int p = 0; p < 14; p++) begin
      if (gaps && $urandom_range(0, 4) == 0) cyc(0, 0, 0, 0, 0, 0, 8'($urandom));
      cyc(1, p == 0, p == 4, p == 6, p == 2, p >= 8 && p <= 11, 8'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < TL; i++) begin m_tr_sh[i] = 0; m_tr[i] = 0; end
    for (int i = 0; i < ZC; i++) begin m_z_sh[i] = 0; m_z[i] = 0; end
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_sof == 0 && out_data == 0, "R10", out_data, 0);
    rst_n = 1;
    // Reset contents: trace, E1 and F1 slots carry zero.
    frame(0);
    // Long trace without length changes: wraps past entry 63 (R4).
    for (int f = 0; f < 80; f++) frame(f[0]);
    // Directed R6: switch to short mid-sequence, then back.
    cfg_trace_short = 1; for (int f = 0; f < 20; f++) frame(0);
    cfg_trace_short = 0; for (int f = 0; f < 3; f++) frame(0);
    // Directed R8: every group bypassed.
    cfg_e1_off = 1; cfg_f1_off = 1; cfg_j0_off = 1; cfg_z0_off = 1; frame(0);
    for (int f = 0; f < 200; f++) begin
      cfg_e1_off = ($urandom_range(0, 3) == 0);
      cfg_f1_off = ($urandom_range(0, 3) == 0);
      cfg_j0_off = ($urandom_range(0, 3) == 0);
      cfg_z0_off = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 29) == 0) cfg_trace_short = ~cfg_trace_short;
      frame(1);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule